// File: doc/BRIEF.md
# Event Notification Interrupt Controller

This block gathers status events from a wireless power transmitter controller and reports them on a single active-low interrupt line. It has two event groups. The link group covers a received packet, a completed remote write, a completed remote read and a performed restart. The protection group covers six level conditions: two temperature limits, bridge over-voltage, bridge short circuit, maximum pulse duty and bridge over-current. Each event always sets its own notification flag. The interrupt line is pulled low only when the event's enable and its group enable are both set.

Software uses a byte-wide register port at fixed addresses. It enables events, reads flags, and writes a one to a group's self-clearing reset bit to clear that group's flags. The pin is driven by a three-state machine: PIN_IDLE (line high), PIN_ACTIVE (line low) and PIN_RELEASE (line high for one cycle after a reset write). It moves IDLE to ACTIVE when an enabled flag is pending. It moves ACTIVE to RELEASE on a reset write, and ACTIVE to IDLE when nothing enabled remains pending. RELEASE goes to ACTIVE if an enabled flag is still pending and to IDLE otherwise; another reset write keeps it in RELEASE. A reset write seen in IDLE keeps it in IDLE.

An operating-mode input decides which link events count. In autonomous mode, certain faults also raise a restart request.

Top module: `evt_irq_ctrl`

## Requirements
- R1: After synchronous reset, irq_n is 1 and restart_req is 0. All flags and enables read 0, and an unmapped address reads 0.
- R2: irq_n falls on the second rising edge after an enabled event is first sampled, which is one edge after its flag becomes readable. When an enable is set over a flag that is already set, irq_n falls on the edge after the enabling write.
- R3: Register 0x1B holds the link group. Bit 1 is packet received, bit 2 is write done, bit 3 is read done and bit 4 is restart performed. Bit 7 is the link group enable, and bit 0 is a write-one reset that always reads 0.
- R4: Register 0x1D bits 5..0 hold the protection flags, in order: temperature 1, temperature 2, over-voltage, short circuit, pulse duty, over-current. Register 0x1F bits 5..0 are the per-event enables. Register 0x1C bit 1 is the protection group enable and bit 0 is its write-one reset, which reads 0.
- R5: An event whose enable is 0 still sets its flag, and irq_n stays 1.
- R6: The packet-received flag is set only when auto_mode is 0. The write-done and read-done flags are set only when auto_mode is 1.
- R7: With auto_mode at 1, the following raise restart_req for exactly one cycle, starting on the edge after they are sampled, and set flag 0x1B bit 4: link_err, temperature 1, temperature 2, over-voltage and pulse duty. Short circuit and over-current do not, and nothing does with auto_mode at 0.
- R8: Writing 1 to a group reset bit clears that group's flags and drives irq_n to 1 on that edge. On the next edge irq_n returns to 0 if an enabled flag is still set. An event sampled on the same edge as the reset keeps its flag.
- R9: Flag bits are read-only: writes to them have no effect.
- R10: irq_n is the inverse of the OR of both groups' (flag AND event enable AND group enable). With 0x1C bit 1 at 0, no protection flag pulls irq_n low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_mode | input | 1 | 1 = autonomous power-control mode, 0 = host-controlled mode |
| pkt_rx | input | 1 | Packet received pulse |
| wr_done | input | 1 | Remote write completion pulse |
| rd_done | input | 1 | Remote read completion pulse |
| link_err | input | 1 | Remote access with no completion |
| prot_cond | input | N_PROT | Protection conditions, bit order as in R4 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq_n | output | 1 | Interrupt, active low, registered |
| restart_req | output | 1 | Restart request pulse |

## Verification
A flag that fails to latch shows up on the next read of its register, one edge after the event. A wrong pin state shows as irq_n at the wrong level one edge after the flag or enable changes. A machine stuck in PIN_RELEASE or PIN_ACTIVE after a reset write is caught by the two irq_n samples taken on that edge and the following one. Mode gating and restart selection faults appear as an extra or missing flag bit, or a wrong restart_req level, in the cycle right after the stimulus.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int N_LINK = 4;

    localparam logic [ADDR_W-1:0] A_LINK = 8'h1B;
    localparam logic [ADDR_W-1:0] A_PGRP = 8'h1C;
    localparam logic [ADDR_W-1:0] A_PFLG = 8'h1D;
    localparam logic [ADDR_W-1:0] A_PEN  = 8'h1F;

    localparam int CLR_BIT       = 0;
    localparam int LINK_FLAG_LSB = 1;
    localparam int LINK_EN_BIT   = 7;
    localparam int PGRP_EN_BIT   = 1;

    localparam int IDX_PKT = 0;
    localparam int IDX_WR  = 1;
    localparam int IDX_RD  = 2;
    localparam int IDX_RST = 3;

    typedef enum logic [1:0] {
        PIN_IDLE    = 2'd0,
        PIN_ACTIVE  = 2'd1,
        PIN_RELEASE = 2'd2
    } pin_state_e;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] flags_o
);
    logic [W-1:0] flag_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                flag_q[i] <= 1'b0;
            else if (set_i[i])
                flag_q[i] <= 1'b1;
            else if (clr_i)
                flag_q[i] <= 1'b0;
        end
    end

    assign flags_o = flag_q;
endmodule

// File: rtl/evt_csr.sv
module evt_csr
    import evt_irq_pkg::*;
#(
    parameter int N_PROT = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_LINK-1:0] link_flags,
    input  logic [N_PROT-1:0] prot_flags,
    output logic [DATA_W-1:0] rdata,
    output logic              link_en,
    output logic              pgrp_en,
    output logic [N_PROT-1:0] prot_en,
    output logic              link_clr,
    output logic              prot_clr
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            link_en <= 1'b0;
            pgrp_en <= 1'b0;
            prot_en <= '0;
        end else if (we) begin
            if (addr == A_LINK) link_en <= wdata[LINK_EN_BIT];
            if (addr == A_PGRP) pgrp_en <= wdata[PGRP_EN_BIT];
            if (addr == A_PEN)  prot_en <= wdata[N_PROT-1:0];
        end
    end

    assign link_clr = we && (addr == A_LINK) && wdata[CLR_BIT];
    assign prot_clr = we && (addr == A_PGRP) && wdata[CLR_BIT];

    always_comb begin
        rdata = '0;
        case (addr)
            A_LINK: begin
                rdata[LINK_EN_BIT]                = link_en;
                rdata[LINK_FLAG_LSB +: N_LINK]    = link_flags;
            end
            A_PGRP: rdata[PGRP_EN_BIT]   = pgrp_en;
            A_PFLG: rdata[N_PROT-1:0]    = prot_flags;
            A_PEN:  rdata[N_PROT-1:0]    = prot_en;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/evt_irq_fsm.sv
module evt_irq_fsm
    import evt_irq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pending_i,
    input  logic release_i,
    output logic irq_n_o
);
    pin_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PIN_IDLE: begin
                if (!release_i && pending_i) state_d = PIN_ACTIVE;
            end
            PIN_ACTIVE: begin
                if (release_i)       state_d = PIN_RELEASE;
                else if (!pending_i) state_d = PIN_IDLE;
            end
            PIN_RELEASE: begin
                if (release_i)      state_d = PIN_RELEASE;
                else if (pending_i) state_d = PIN_ACTIVE;
                else                state_d = PIN_IDLE;
            end
            default: state_d = PIN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PIN_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_n_o <= 1'b1;
        else     irq_n_o <= (state_d != PIN_ACTIVE);
    end
endmodule

// File: rtl/evt_irq_ctrl.sv
module evt_irq_ctrl
    import evt_irq_pkg::*;
#(
    parameter int                N_PROT       = 6,
    parameter logic [N_PROT-1:0] RESTART_MASK = 6'b010111
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              auto_mode,
    input  logic              pkt_rx,
    input  logic              wr_done,
    input  logic              rd_done,
    input  logic              link_err,
    input  logic [N_PROT-1:0] prot_cond,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_n,
    output logic              restart_req
);
    logic [N_LINK-1:0] link_set, link_flags;
    logic [N_PROT-1:0] prot_flags, prot_en;
    logic link_en, pgrp_en, link_clr, prot_clr;
    logic restart_cond, pending;

    assign restart_cond = auto_mode & (link_err | (|(prot_cond & RESTART_MASK)));

    always_comb begin
        link_set          = '0;
        link_set[IDX_PKT] = ~auto_mode & pkt_rx;
        link_set[IDX_WR]  = auto_mode & wr_done;
        link_set[IDX_RD]  = auto_mode & rd_done;
        link_set[IDX_RST] = restart_cond;
    end

    evt_flag_bank #(.W(N_LINK)) u_link_flags (
        .clk(clk), .rst(rst), .set_i(link_set), .clr_i(link_clr), .flags_o(link_flags)
    );

    evt_flag_bank #(.W(N_PROT)) u_prot_flags (
        .clk(clk), .rst(rst), .set_i(prot_cond), .clr_i(prot_clr), .flags_o(prot_flags)
    );

    evt_csr #(.N_PROT(N_PROT)) u_csr (
        .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .link_flags(link_flags), .prot_flags(prot_flags), .rdata(reg_rdata),
        .link_en(link_en), .pgrp_en(pgrp_en), .prot_en(prot_en),
        .link_clr(link_clr), .prot_clr(prot_clr)
    );

    assign pending = (link_en & (|link_flags)) | (pgrp_en & (|(prot_flags & prot_en)));

    evt_irq_fsm u_fsm (
        .clk(clk), .rst(rst), .pending_i(pending),
        .release_i(link_clr | prot_clr), .irq_n_o(irq_n)
    );

    always_ff @(posedge clk) begin
        if (rst) restart_req <= 1'b0;
        else     restart_req <= restart_cond;
    end
endmodule

// File: rtl/evt_irq_chk.sv
module evt_irq_chk
    import evt_irq_pkg::*;
#(
    parameter int N_PROT = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              auto_mode,
    input logic [N_PROT-1:0] prot_cond,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq_n,
    input logic              restart_req,
    input logic              pending,
    input logic [N_LINK-1:0] link_flags,
    input logic [N_PROT-1:0] prot_flags
);
    p_reset_idle_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> irq_n);

    p_low_needs_pending_r2: assert property (@(posedge clk) disable iff (rst)
        !irq_n |-> $past(pending));

    p_disabled_latch_r5: assert property (@(posedge clk) disable iff (rst)
        (|prot_cond) |=> (|prot_flags));

    p_pkt_host_only_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(link_flags[IDX_PKT]) |-> $past(!auto_mode));

    p_wr_auto_only_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(link_flags[IDX_WR]) |-> $past(auto_mode));

    p_restart_auto_r7: assert property (@(posedge clk) disable iff (rst)
        restart_req |-> $past(auto_mode));

    p_reset_write_release_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && (reg_addr == A_LINK || reg_addr == A_PGRP) && reg_wdata[CLR_BIT]) |=> irq_n);
endmodule

bind evt_irq_ctrl evt_irq_chk #(.N_PROT(N_PROT)) u_chk (
    .clk(clk), .rst(rst), .auto_mode(auto_mode), .prot_cond(prot_cond),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .irq_n(irq_n), .restart_req(restart_req), .pending(pending),
    .link_flags(link_flags), .prot_flags(prot_flags)
);

// File: tb/evt_irq_ctrl_tb.sv
module evt_irq_ctrl_tb;
    localparam int NP = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic auto_mode = 1'b0, pkt_rx = 1'b0, wr_done = 1'b0, rd_done = 1'b0, link_err = 1'b0;
    logic [NP-1:0] prot_cond = '0;
    logic reg_we = 1'b0;
    logic [7:0] reg_addr = '0, reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq_n, restart_req;

    always #5 clk = ~clk;

    evt_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .auto_mode(auto_mode), .pkt_rx(pkt_rx),
        .wr_done(wr_done), .rd_done(rd_done), .link_err(link_err),
        .prot_cond(prot_cond), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_n(irq_n),
        .restart_req(restart_req)
    );

    typedef struct {
        string      req;
        int         kind;   // 0 irq_n, 1 reg_rdata, 2 restart_req
        logic [7:0] exp;
    } item_t;

    item_t q[$];
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Monitor: compares every queued expectation at the falling edge
    always @(negedge clk) begin
        while (q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = q.pop_front();
            case (it.kind)
                0:       act = {7'b0, irq_n};
                1:       act = reg_rdata;
                default: act = {7'b0, restart_req};
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic exp_irq(string r, logic v);
        q.push_back('{r, 0, {7'b0, v}});
    endtask

    task automatic exp_rst(string r, logic v);
        q.push_back('{r, 2, {7'b0, v}});
    endtask

    task automatic exp_rd(string r, logic [7:0] a, logic [7:0] v);
        reg_addr = a;
        q.push_back('{r, 1, v});
        tick();
    endtask

    task automatic wr(logic [7:0] a, logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_we = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(int which, logic [NP-1:0] pm);
        case (which)
            0: pkt_rx = 1'b1;
            1: wr_done = 1'b1;
            2: rd_done = 1'b1;
            3: link_err = 1'b1;
            default: prot_cond = pm;
        endcase
        tick();
        pkt_rx = 1'b0; wr_done = 1'b0; rd_done = 1'b0; link_err = 1'b0; prot_cond = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        // R1: reset state
        exp_irq("R1", 1'b1);
        exp_rst("R1", 1'b0);
        exp_rd("R1", 8'h1B, 8'h00);
        exp_rd("R1", 8'h1C, 8'h00);
        exp_rd("R1", 8'h1D, 8'h00);
        exp_rd("R1", 8'h1F, 8'h00);
        exp_rd("R1", 8'h20, 8'h00);
        rst = 1'b0;
        tick();

        // R5: disabled link event still latches, pin stays high
        pulse(0, '0);
        exp_irq("R5", 1'b1);
        exp_rd("R5", 8'h1B, 8'h02);
        exp_irq("R5", 1'b1);

        // R2, R3: enabling over a set flag
        wr(8'h1B, 8'h80);
        exp_irq("R2", 1'b1);
        tick();
        exp_irq("R2", 1'b0);
        exp_rd("R3", 8'h1B, 8'h82);

        // R8: reset write releases and clears; R3 reset bit reads 0
        wr(8'h1B, 8'h81);
        exp_irq("R8", 1'b1);
        exp_rd("R3", 8'h1B, 8'h80);
        exp_irq("R8", 1'b1);

        // R6: mode gating
        pulse(1, '0);
        exp_rd("R6", 8'h1B, 8'h80);
        auto_mode = 1'b1;
        tick();
        pulse(0, '0);
        exp_rd("R6", 8'h1B, 8'h80);
        pulse(1, '0);
        exp_rd("R6", 8'h1B, 8'h84);
        pulse(2, '0);
        exp_rd("R6", 8'h1B, 8'h8C);
        exp_irq("R2", 1'b0);
        wr(8'h1B, 8'h81);
        tick();

        // R7: restart selection
        pulse(3, '0);
        exp_rst("R7", 1'b1);
        exp_rd("R7", 8'h1B, 8'h90);
        exp_rst("R7", 1'b0);
        wr(8'h1B, 8'h81);
        tick();
        pulse(4, 6'b001000);
        exp_rst("R7", 1'b0);
        exp_rd("R7", 8'h1B, 8'h80);
        pulse(4, 6'b010000);
        exp_rst("R7", 1'b1);
        exp_rd("R7", 8'h1B, 8'h90);
        wr(8'h1B, 8'h81);
        tick();
        auto_mode = 1'b0;
        tick();
        pulse(4, 6'b000001);
        exp_rst("R7", 1'b0);
        exp_rd("R7", 8'h1B, 8'h80);

        // R4, R10: protection group enables
        wr(8'h1B, 8'h00);
        wr(8'h1C, 8'h01);
        tick();
        exp_rd("R8", 8'h1D, 8'h00);
        wr(8'h1F, 8'h08);
        pulse(4, 6'b100000);
        exp_rd("R4", 8'h1D, 8'h20);
        exp_irq("R5", 1'b1);
        pulse(4, 6'b001000);
        exp_rd("R4", 8'h1D, 8'h28);
        exp_irq("R10", 1'b1);
        wr(8'h1C, 8'h02);
        exp_irq("R10", 1'b1);
        tick();
        exp_irq("R10", 1'b0);
        exp_rd("R4", 8'h1C, 8'h02);
        exp_rd("R4", 8'h1F, 8'h08);

        // R9: flag bits are read-only
        wr(8'h1D, 8'h00);
        exp_rd("R9", 8'h1D, 8'h28);
        wr(8'h1B, 8'h1E);
        exp_rd("R9", 8'h1B, 8'h00);
        exp_irq("R9", 1'b0);

        // R8: reset with coincident event, then plain reset
        prot_cond = 6'b001000;
        tick();
        wr(8'h1C, 8'h03);
        exp_irq("R8", 1'b1);
        tick();
        exp_irq("R8", 1'b0);
        exp_rd("R8", 8'h1D, 8'h08);
        prot_cond = '0;
        wr(8'h1C, 8'h03);
        exp_irq("R8", 1'b1);
        tick();
        exp_irq("R8", 1'b1);
        exp_rd("R8", 8'h1D, 8'h00);

        tick();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule